// File: doc/BRIEF.md
# Two-Lane Serial Sample Deserializer with Frame-Nibble Alignment

This block sits behind a 1:4 input stage that has already cut each of two serial data lanes, plus a frame-clock lane, into 4-bit nibbles. The nibble boundary that stage produces is arbitrary with respect to the sample boundary. The block shifts all three nibble streams by a common bit offset of 0 to 3. It chooses that offset by trying each value in turn until the shifted frame nibbles alternate between all-ones and all-zeros.

Once aligned, the block joins the two nibbles of each lane into one byte. It puts the two bytes together into a 16-bit word, keeps the low 14 bits as the sample, and converts the sample to two's complement when the source sends offset binary. Each sample comes out with a one-cycle valid strobe. If no offset yields the frame pattern, an error flag is raised instead and no sample is ever marked valid. A new capture request restarts the search at any time.

Top module: `twolane_frame_deser`

## Requirements
- R1: After a synchronous reset, `sample`, `sample_valid`, `aligned` and `align_err` are all zero, and the block waits for a capture request.
- R2: A capture request starts a search at offset 0 and tries offsets 0, 1, 2 and 3 in that order. Each trial spends one settle cycle, then checks consecutive shifted frame nibbles. A trial ends at the first nibble that is neither 4'b1111 nor 4'b0000, or that equals its predecessor. If the correct offset is s and the capture request is sampled at clock edge 0, `aligned` is first high after edge 8+2s.
- R3: An offset is accepted after 8 consecutive shifted frame nibbles that alternate between 4'b1111 and 4'b0000, in either starting phase. A stream whose word boundary lies k bits after a nibble boundary therefore locks at offset k mod 4, for any k from 0 to 7. While aligned, the offset does not change.
- R4: In every input nibble, bit 3 is the earliest serial bit. Each lane carries 8 bits per sample, which is two nibbles. A sample's bits on a lane begin with the shifted nibble whose frame nibble is 4'b1111 and end with the following nibble, whose frame nibble is 4'b0000.
- R5: Lane 0 (input bits 3:0) supplies word bits 15:8 and lane 1 (input bits 7:4) supplies word bits 7:0. Word bits 15:14 are padding and are dropped, so `sample` = word[13:0].
- R6: With `cfg_msb_first`=1, the first serial bit of a lane is the most significant bit of that lane's byte. With `cfg_msb_first`=0, it is the least significant bit.
- R7: With `cfg_twos_comp`=0, the input is offset binary and `sample` bit 13 is inverted. With `cfg_twos_comp`=1, the low 14 word bits pass through unchanged.
- R8: If none of the four offsets matches, `align_err` goes high, `aligned` stays low, and `sample_valid` never asserts until the next capture request.
- R9: `sample_valid` asserts only while `aligned` is high, never in two consecutive cycles, and yields samples in stream order without gaps.
- R10: A capture request while aligned or in error clears both flags on the next cycle and starts a fresh search at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one nibble per lane per cycle |
| rst | input | 1 | Synchronous active-high reset |
| capture_req | input | 1 | One-cycle request to (re)start the alignment search |
| cfg_msb_first | input | 1 | 1 = first serial bit is the byte MSB, 0 = LSB first |
| cfg_twos_comp | input | 1 | 1 = input already two's complement, 0 = offset binary |
| data_nib | input | 8 | Data nibbles; lane 0 in bits 3:0, lane 1 in bits 7:4; bit 3 of each is earliest |
| frame_nib | input | 4 | Frame-clock nibble, bit 3 earliest |
| sample | output | 14 | Recovered two's-complement sample |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |
| aligned | output | 1 | Alignment found and held |
| align_err | output | 1 | No offset produced the frame pattern |

## Verification
A serializer model produces the three bit streams with a word boundary placed at each of the eight bit positions within two nibbles. This tells a correct offset choice apart from a phase-insensitive one, and it shows that offsets 4 to 7 fold onto 0 to 3. Every pairing of bit order and number format is driven with random sample sequences that have distinct values. Directed runs cross the offset-binary and two's-complement sign boundaries (0x3FFF to 0x0000, and 0x1FFF to 0x2000), so a byte swap, a reversed bit order or a missing sign-bit inversion all give a wrong value. A frame stream with a 4-bit period is the case that no offset can match. It exercises the error path, and a capture request afterwards shows recovery.

// File: rtl/sdeser_pkg.sv
package sdeser_pkg;

    localparam int NIB_W    = 4;
    localparam int LANES    = 2;
    localparam int BYTE_W   = 2 * NIB_W;
    localparam int WORD_W   = LANES * BYTE_W;
    localparam int SAMPLE_W = 14;
    localparam int PAIRS    = 4;
    localparam int SLIP_W   = $clog2(NIB_W);

    typedef enum logic [1:0] {
        AL_IDLE,
        AL_SEARCH,
        AL_LOCKED,
        AL_ERROR
    } align_state_e;

    typedef struct packed {
        logic                valid;
        logic [SAMPLE_W-1:0] data;
    } sample_t;

    // Serial order is earliest-at-MSB; flip for LSB-first streams.
    function automatic logic [BYTE_W-1:0] order_byte(
        input logic [BYTE_W-1:0] raw,
        input logic              msb_first
    );
        logic [BYTE_W-1:0] r;
        for (int k = 0; k < BYTE_W; k++) begin
            r[k] = msb_first ? raw[k] : raw[BYTE_W-1-k];
        end
        return r;
    endfunction

    function automatic logic [SAMPLE_W-1:0] to_twos(
        input logic [SAMPLE_W-1:0] s,
        input logic                is_twos
    );
        logic [SAMPLE_W-1:0] r;
        r = s;
        if (!is_twos) begin
            r[SAMPLE_W-1] = ~s[SAMPLE_W-1];
        end
        return r;
    endfunction

endpackage

// File: rtl/nib_slip.sv
module nib_slip #(
    parameter int W  = sdeser_pkg::NIB_W,
    parameter int SW = sdeser_pkg::SLIP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] slip,
    input  logic [W-1:0]  nib_in,
    output logic [W-1:0]  nib_out
);
    logic [W-1:0]   prev_q;
    logic [2*W-1:0] window;
    logic [2*W-1:0] shifted;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= nib_in;
    end

    // Older nibble sits in the upper half; a larger slip starts later in time.
    always_comb begin
        window  = {prev_q, nib_in};
        shifted = window >> (W - int'(slip));
        nib_out = shifted[W-1:0];
    end
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner #(
    parameter int W     = sdeser_pkg::NIB_W,
    parameter int SW    = sdeser_pkg::SLIP_W,
    parameter int PAIRS = sdeser_pkg::PAIRS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     capture_req,
    input  logic [W-1:0]             fr_nib,
    output logic [SW-1:0]            slip,
    output sdeser_pkg::align_state_e state
);
    import sdeser_pkg::*;

    localparam int NEED  = 2 * PAIRS - 1;
    localparam int RUN_W = $clog2(2 * PAIRS);
    localparam logic [SW-1:0] SLIP_LAST = SW'(W - 1);

    logic [W-1:0]     fr_q;
    logic [RUN_W-1:0] run_q;
    logic             settle_q;
    logic             good;

    always_comb begin
        good = ((fr_nib == '1) && (fr_q == '0)) ||
               ((fr_nib == '0) && (fr_q == '1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= AL_IDLE;
            slip     <= '0;
            run_q    <= '0;
            settle_q <= 1'b0;
            fr_q     <= '0;
        end else begin
            fr_q <= fr_nib;
            if (capture_req) begin
                state    <= AL_SEARCH;
                slip     <= '0;
                run_q    <= '0;
                settle_q <= 1'b1;
            end else if (state == AL_SEARCH) begin
                if (settle_q) begin
                    settle_q <= 1'b0;
                    run_q    <= '0;
                end else if (good) begin
                    if (run_q == RUN_W'(NEED - 1)) state <= AL_LOCKED;
                    else                           run_q <= run_q + 1'b1;
                end else if (slip == SLIP_LAST) begin
                    state <= AL_ERROR;
                end else begin
                    slip     <= slip + 1'b1;
                    settle_q <= 1'b1;
                    run_q    <= '0;
                end
            end
        end
    end

    p_capture_restarts_r10: assert property (@(posedge clk) disable iff (rst)
        capture_req |=> (state == AL_SEARCH && slip == '0));

    p_error_after_sweep_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(state == AL_ERROR) |-> (slip == SLIP_LAST));

    p_slip_held_r3: assert property (@(posedge clk) disable iff (rst)
        (state == AL_LOCKED && $past(state) == AL_LOCKED) |-> $stable(slip));
endmodule

// File: rtl/word_builder.sv
module word_builder #(
    parameter int W        = sdeser_pkg::NIB_W,
    parameter int LANES    = sdeser_pkg::LANES,
    parameter int SAMPLE_W = sdeser_pkg::SAMPLE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               locked,
    input  logic               capture_req,
    input  logic               msb_first,
    input  logic               twos_comp,
    input  logic [W-1:0]       fr_nib,
    input  logic [LANES*W-1:0] lane_nib,
    output sdeser_pkg::sample_t out
);
    import sdeser_pkg::*;

    localparam int BW = 2 * W;
    localparam int WW = LANES * BW;

    logic [LANES*W-1:0] first_q;
    logic               have_q;
    logic [WW-1:0]      word;

    // Lane 0 fills the top byte of the word, later lanes go below it.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            word[WW-1-l*BW -: BW] = order_byte({first_q[l*W +: W], lane_nib[l*W +: W]},
                                               msb_first);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q  <= '0;
            have_q   <= 1'b0;
            out      <= '0;
        end else if (!locked || capture_req) begin
            have_q    <= 1'b0;
            out.valid <= 1'b0;
        end else begin
            out.valid <= 1'b0;
            if (fr_nib == '1) begin
                first_q <= lane_nib;
                have_q  <= 1'b1;
            end else if (fr_nib == '0 && have_q) begin
                out.data  <= to_twos(word[SAMPLE_W-1:0], twos_comp);
                out.valid <= 1'b1;
                have_q    <= 1'b0;
            end else begin
                have_q <= 1'b0;
            end
        end
    end

    p_valid_spacing_r9: assert property (@(posedge clk) disable iff (rst)
        out.valid |=> !out.valid);

    p_valid_after_low_frame_r4: assert property (@(posedge clk) disable iff (rst)
        out.valid |-> ($past(fr_nib) == '0));
endmodule

// File: rtl/twolane_frame_deser.sv
module twolane_frame_deser #(
    parameter int NIB_W    = sdeser_pkg::NIB_W,
    parameter int LANES    = sdeser_pkg::LANES,
    parameter int SAMPLE_W = sdeser_pkg::SAMPLE_W,
    parameter int PAIRS    = sdeser_pkg::PAIRS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   capture_req,
    input  logic                   cfg_msb_first,
    input  logic                   cfg_twos_comp,
    input  logic [LANES*NIB_W-1:0] data_nib,
    input  logic [NIB_W-1:0]       frame_nib,
    output logic [SAMPLE_W-1:0]    sample,
    output logic                   sample_valid,
    output logic                   aligned,
    output logic                   align_err
);
    import sdeser_pkg::*;

    localparam int SW = $clog2(NIB_W);

    logic [SW-1:0]          slip;
    align_state_e           st;
    logic [NIB_W-1:0]       fr_sl;
    logic [LANES*NIB_W-1:0] data_sl;
    sample_t                smp;

    nib_slip #(.W(NIB_W), .SW(SW)) u_frame_slip (
        .clk(clk), .rst(rst), .slip(slip), .nib_in(frame_nib), .nib_out(fr_sl)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_data_slip
        nib_slip #(.W(NIB_W), .SW(SW)) u_slip (
            .clk    (clk),
            .rst    (rst),
            .slip   (slip),
            .nib_in (data_nib[l*NIB_W +: NIB_W]),
            .nib_out(data_sl[l*NIB_W +: NIB_W])
        );
    end

    frame_aligner #(.W(NIB_W), .SW(SW), .PAIRS(PAIRS)) u_align (
        .clk(clk), .rst(rst), .capture_req(capture_req),
        .fr_nib(fr_sl), .slip(slip), .state(st)
    );

    word_builder #(.W(NIB_W), .LANES(LANES), .SAMPLE_W(SAMPLE_W)) u_build (
        .clk        (clk),
        .rst        (rst),
        .locked     (st == AL_LOCKED),
        .capture_req(capture_req),
        .msb_first  (cfg_msb_first),
        .twos_comp  (cfg_twos_comp),
        .fr_nib     (fr_sl),
        .lane_nib   (data_sl),
        .out        (smp)
    );

    assign sample       = smp.data;
    assign sample_valid = smp.valid;
    assign aligned      = (st == AL_LOCKED);
    assign align_err    = (st == AL_ERROR);

    p_valid_needs_lock_r9: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> aligned);

    p_no_valid_in_error_r8: assert property (@(posedge clk) disable iff (rst)
        align_err |-> !sample_valid);
endmodule

// File: tb/tb_twolane_frame_deser.sv
`timescale 1ns/1ps
module tb_twolane_frame_deser;

    localparam int NSAMP = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        capture_req = 1'b0;
    logic        cfg_msb_first = 1'b1;
    logic        cfg_twos_comp = 1'b1;
    logic [7:0]  data_nib = '0;
    logic [3:0]  frame_nib = '0;
    logic [13:0] sample;
    logic        sample_valid;
    logic        aligned;
    logic        align_err;

    int n_chk = 0;
    int n_err = 0;

    int g_off, g_base, g_stride;
    bit g_msb, g_twos, g_bad;

    always #2 clk = ~clk;

    twolane_frame_deser dut (
        .clk(clk), .rst(rst), .capture_req(capture_req),
        .cfg_msb_first(cfg_msb_first), .cfg_twos_comp(cfg_twos_comp),
        .data_nib(data_nib), .frame_nib(frame_nib),
        .sample(sample), .sample_valid(sample_valid),
        .aligned(aligned), .align_err(align_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_val(input int n);
        return (g_base + n * g_stride) & 16'h3FFF;
    endfunction

    function automatic logic [15:0] word_of(input int n);
        logic [13:0] s;
        s = 14'(exp_val(n));
        if (!g_twos) s[13] = ~s[13];
        return {2'b00, s};
    endfunction

    function automatic bit data_bit(input int lane, input int t);
        int n, p;
        logic [15:0] w;
        if (t < g_off) return 1'b0;
        n = (t - g_off) / 8;
        p = (t - g_off) % 8;
        w = word_of(n);
        if (g_msb) return w[15 - lane * 8 - p];
        return w[8 - lane * 8 + p];
    endfunction

    function automatic bit frame_bit(input int t);
        int q;
        if (g_bad) return (t % 4) < 2;
        q = (((t - g_off) % 8) + 8) % 8;
        return q < 4;
    endfunction

    function automatic logic [3:0] nib_of(input int kind, input int c);
        logic [3:0] r;
        for (int k = 0; k < 4; k++) begin
            r[3 - k] = (kind == 2) ? frame_bit(4 * c + k) : data_bit(kind, 4 * c + k);
        end
        return r;
    endfunction

    task automatic drive(input int c);
        data_nib  = {nib_of(1, c), nib_of(0, c)};
        frame_nib = nib_of(2, c);
    endtask

    task automatic run_scen(input bit msb, input bit twos, input int off,
                            input int base, input int stride);
        int  s, idx, got;
        bit  started, prev_v, found;
        g_msb = msb; g_twos = twos; g_off = off; g_base = base; g_stride = stride;
        g_bad = 1'b0;
        s = off % 4;
        @(negedge clk);
        cfg_msb_first = msb;
        cfg_twos_comp = twos;
        drive(0);
        capture_req = 1'b1;
        started = 1'b0; prev_v = 1'b0; idx = 0; got = 0;
        for (int i = 1; i < 20 + 2 * NSAMP; i++) begin
            @(negedge clk);
            capture_req = 1'b0;
            if (i == 1)
                chk(!aligned && !align_err, "R10 flags cleared by capture", {aligned, align_err}, 0);
            if (i == 8 + 2 * s)
                chk(!aligned, "R2 not yet aligned", aligned, 0);
            if (i == 9 + 2 * s)
                chk(aligned, "R2 R3 aligned at expected cycle", aligned, 1);
            if (sample_valid) begin
                chk(aligned && !prev_v, "R9 valid spacing and lock", {aligned, prev_v}, 2);
                if (!started) begin
                    found = 1'b0;
                    for (int n = 0; n <= NSAMP; n++) begin
                        if (!found && exp_val(n) == int'(sample)) begin
                            found = 1'b1;
                            idx = n + 1;
                        end
                    end
                    chk(found, "R4 R5 R6 R7 first sample", sample, exp_val(0));
                    started = 1'b1;
                end else begin
                    chk(int'(sample) == exp_val(idx), "R5 R6 R7 sample value", sample, exp_val(idx));
                    idx++;
                end
                got++;
            end
            prev_v = sample_valid;
            drive(i);
        end
        chk(got >= NSAMP - 8, "R4 R9 sample count", got, NSAMP - 8);
    endtask

    task automatic run_bad();
        bit any_v;
        g_bad = 1'b1; g_off = 0;
        @(negedge clk);
        drive(0);
        capture_req = 1'b1;
        any_v = 1'b0;
        for (int i = 1; i < 40; i++) begin
            @(negedge clk);
            capture_req = 1'b0;
            if (sample_valid) any_v = 1'b1;
            if (i == 14)
                chk(align_err && !aligned, "R8 error after full sweep", {align_err, aligned}, 2);
            drive(i);
        end
        chk(!any_v, "R8 no valid while unmatched", any_v, 0);
        chk(align_err, "R8 error held", align_err, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed0;
        seed0 = $urandom(32'd4411);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sample == '0 && !sample_valid && !aligned && !align_err,
            "R1 reset outputs", {sample, sample_valid, aligned, align_err}, 0);

        // Directed: sign boundaries in both formats.
        run_scen(1'b1, 1'b0, 3, 16'h3FFC, 1);
        run_scen(1'b0, 1'b1, 5, 16'h1FFE, 1);
        run_scen(1'b1, 1'b1, 7, 16'h3FFD, 1);

        for (int m = 0; m < 4; m++) begin
            for (int off = 0; off < 8; off++) begin
                run_scen(m[1], m[0], off, int'($urandom & 16'h3FFF),
                         int'(($urandom & 16'h0FFF) | 1));
            end
        end

        run_bad();
        // R10: recovery from error through a fresh capture request.
        run_scen(1'b0, 1'b0, 2, int'($urandom & 16'h3FFF), 37);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule